// File: doc/BRIEF.md
# Beat-to-Quadword Landing Bridge

The bridge takes a stream of 32-bit data beats and turns every group of four into a single 128-bit memory write. Beats enter over a valid/ready handshake. The first beat of a group fills the lowest 32 bits of the quadword. When the fourth beat is accepted, the block raises one write request toward memory. That request carries a target address, the packed data and a 16-bit byte-enable mask. It stays up until memory acknowledges it.

The target address is a base-address parameter plus a write offset that the block keeps itself. After each acknowledged write the offset steps forward by 16 bytes, so back-to-back transfers fill consecutive slots. A producer that wants to overwrite one fixed slot instead pulses a rewind input between transfers. The pulse returns the offset to zero, and the next write lands at the base again.

A beat that carries the last flag closes its group at once, even if fewer than four beats have arrived. A sticky output records that such a beat has been accepted since reset. Rewind never clears that output.

Top module: `qword_landing_bridge`

## Requirements
- R1: After reset, `beat_ready_o` is 1, `wr_valid_o` is 0 and `last_seen_o` is 0.
- R2: Four accepted beats are packed little-endian: beat 0 in `wr_data_o[31:0]`, beat 1 in [63:32], beat 2 in [95:64], beat 3 in [127:96]. The write request appears in the cycle after the fourth beat is accepted.
- R3: `wr_addr_o` equals `BASE_ADDR` plus the write offset. The offset starts at 0 and grows by 16 after each acknowledged write. With no rewind, successive writes go to BASE, BASE+16, BASE+32, and so on.
- R4: A write built from four beats drives all 16 bits of `wr_be_o` high.
- R5: While a write is pending, `beat_ready_o` is 0 and no beat is accepted. Address, data and byte enables hold steady until `wr_ack_i`. The cycle after the acknowledge, `wr_valid_o` is 0 and `beat_ready_o` is 1. A `wr_ack_i` with no write pending has no effect.
- R6: A beat with `beat_last_i` = 1 ends its group immediately. The write enables only the byte lanes of the beats received (two beats give 16'h00FF) and carries zero in the unfilled lanes. Accumulated data, enables and position are cleared after every write.
- R7: A one-cycle `rewind_i` pulse sets the offset to zero at the next clock edge, so the next write lands at `BASE_ADDR`. It does not start a write and changes no other state. Rewind is legal only while idle, with no beats collected and no write pending. Any other use is reported as an error in simulation but is still applied.
- R8: `last_seen_o` rises in the cycle after a beat with `beat_last_i` = 1 is accepted. It stays high until reset, including across rewind. Beats without the flag never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid_i | input | 1 | Beat offered |
| beat_data_i | input | 32 | Beat payload |
| beat_last_i | input | 1 | Beat closes the transfer |
| beat_ready_o | output | 1 | Beat can be accepted this cycle |
| rewind_i | input | 1 | Return the write offset to zero |
| wr_valid_o | output | 1 | Quadword write pending |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 128 | Packed quadword |
| wr_be_o | output | 16 | Byte enables |
| wr_ack_i | input | 1 | Memory accepted the pending write |
| last_seen_o | output | 1 | Sticky: a last-flagged beat was accepted |

## Verification
A wrong beat position shows up in the very next write: a payload lands in the wrong lane, or a lane's byte enables are missing. A stale accumulator shows up at the following partial write, as nonzero data or enabled bytes in the unfilled lanes. A wrong offset shows at the next `wr_addr_o`, so the bench checks the address of every write against a count of acknowledges and rewinds. Beats offered while a write is held would corrupt the next quadword, so the bench offers junk beats during each hold.

// File: rtl/qlb_pkg.sv
package qlb_pkg;

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_LAND    = 1'b1
    } land_state_e;

    // Byte-enable mask covering the first n beats of a quadword
    function automatic logic [15:0] lanes_upto(input int n, input int bytes_per_beat);
        logic [15:0] m;
        m = '0;
        for (int b = 0; b < 16; b++)
            if (b < n * bytes_per_beat) m[b] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/beat_packer.sv
module beat_packer
    import qlb_pkg::*;
#(
    parameter int BEAT_W = 32,
    parameter int BEATS  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      beat_valid_i,
    input  logic [BEAT_W-1:0]         beat_data_i,
    input  logic                      beat_last_i,
    output logic                      beat_ready_o,
    input  logic                      land_ack_i,
    output logic                      land_valid_o,
    output logic [BEAT_W*BEATS-1:0]   land_data_o,
    output logic [BEAT_W*BEATS/8-1:0] land_be_o,
    output logic                      idle_o,
    output logic                      take_last_o,
    output logic                      landed_o
);
    localparam int BYTES = BEAT_W / 8;
    localparam int QW    = BEAT_W * BEATS;
    localparam int QB    = QW / 8;
    localparam int POS_W = $clog2(BEATS + 1);

    land_state_e          state;
    logic [POS_W-1:0]     pos;
    logic [QW-1:0]        acc_data;
    logic [QB-1:0]        acc_be;
    logic                 take;

    assign take         = beat_valid_i && (state == ST_COLLECT);
    assign beat_ready_o = (state == ST_COLLECT);
    assign land_valid_o = (state == ST_LAND);
    assign land_data_o  = acc_data;
    assign land_be_o    = acc_be;
    assign idle_o       = (state == ST_COLLECT) && (pos == '0);
    assign take_last_o  = take && beat_last_i;
    assign landed_o     = (state == ST_LAND) && land_ack_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_COLLECT;
            pos      <= '0;
            acc_data <= '0;
            acc_be   <= '0;
        end else begin
            case (state)
                ST_COLLECT: if (take) begin
                    for (int i = 0; i < BEATS; i++) begin
                        if (pos == POS_W'(i)) begin
                            acc_data[i*BEAT_W +: BEAT_W] <= beat_data_i;
                            acc_be[i*BYTES +: BYTES]     <= '1;
                        end
                    end
                    pos <= pos + POS_W'(1);
                    if (pos == POS_W'(BEATS - 1) || beat_last_i)
                        state <= ST_LAND;
                end
                ST_LAND: if (land_ack_i) begin
                    acc_data <= '0;
                    acc_be   <= '0;
                    pos      <= '0;
                    state    <= ST_COLLECT;
                end
                default: state <= ST_COLLECT;
            endcase
        end
    end

    // R2
    quad_close_chk: assert property (@(posedge clk) disable iff (rst)
        (take && pos == POS_W'(BEATS - 1)) |=> land_valid_o);

    // R4
    full_be_chk: assert property (@(posedge clk) disable iff (rst)
        (land_valid_o && pos == POS_W'(BEATS)) |-> (&land_be_o));

    // R6
    cleared_chk: assert property (@(posedge clk) disable iff (rst)
        landed_o |=> (land_be_o == '0 && land_data_o == '0));

endmodule

// File: rtl/slot_offset.sv
module slot_offset #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance_i,
    input  logic              rewind_i,
    output logic [ADDR_W-1:0] offset_o
);
    always_ff @(posedge clk) begin
        if (rst)            offset_o <= '0;
        else if (rewind_i)  offset_o <= '0;
        else if (advance_i) offset_o <= offset_o + ADDR_W'(STEP);
    end

    // R7
    rewind_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rewind_i |=> (offset_o == '0));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance_i && !rewind_i) |=> (offset_o == $past(offset_o) + ADDR_W'(STEP)));

endmodule

// File: rtl/last_seen_latch.sv
module last_seen_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
    end
endmodule

// File: rtl/qword_landing_bridge.sv
module qword_landing_bridge
    import qlb_pkg::*;
#(
    parameter int              BEAT_W    = 32,
    parameter int              BEATS     = 4,
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0008_0000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      beat_valid_i,
    input  logic [BEAT_W-1:0]         beat_data_i,
    input  logic                      beat_last_i,
    output logic                      beat_ready_o,
    input  logic                      rewind_i,
    output logic                      wr_valid_o,
    output logic [ADDR_W-1:0]         wr_addr_o,
    output logic [BEAT_W*BEATS-1:0]   wr_data_o,
    output logic [BEAT_W*BEATS/8-1:0] wr_be_o,
    input  logic                      wr_ack_i,
    output logic                      last_seen_o
);
    localparam int QBYTES = BEAT_W * BEATS / 8;

    logic              idle;
    logic              take_last;
    logic              landed;
    logic [ADDR_W-1:0] offset;

    beat_packer #(.BEAT_W(BEAT_W), .BEATS(BEATS)) packer_i (
        .clk          (clk),
        .rst          (rst),
        .beat_valid_i (beat_valid_i),
        .beat_data_i  (beat_data_i),
        .beat_last_i  (beat_last_i),
        .beat_ready_o (beat_ready_o),
        .land_ack_i   (wr_ack_i),
        .land_valid_o (wr_valid_o),
        .land_data_o  (wr_data_o),
        .land_be_o    (wr_be_o),
        .idle_o       (idle),
        .take_last_o  (take_last),
        .landed_o     (landed)
    );

    slot_offset #(.ADDR_W(ADDR_W), .STEP(QBYTES)) offset_i (
        .clk       (clk),
        .rst       (rst),
        .advance_i (landed),
        .rewind_i  (rewind_i),
        .offset_o  (offset)
    );

    last_seen_latch seen_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (take_last),
        .flag_o (last_seen_o)
    );

    assign wr_addr_o = BASE_ADDR + offset;

    // R7 misuse detection: rewind outside idle is reported, still applied
    rewind_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rewind_i |-> idle)
        else $error("rewind pulsed while a transfer is in progress");

    // R5
    pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ack_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_be_o)));

    // R5
    no_take_pending_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> !beat_ready_o);

    // R8
    last_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_i && beat_ready_o && beat_last_i) |=> last_seen_o);

    // R8
    last_hold_chk: assert property (@(posedge clk) disable iff (rst)
        last_seen_o |=> last_seen_o);

endmodule

// File: tb/qword_landing_bridge_tb_top.sv
module qword_landing_bridge_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h0008_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         beat_valid = 1'b0;
    logic [31:0]  beat_data  = '0;
    logic         beat_last  = 1'b0;
    logic         beat_ready;
    logic         rewind = 1'b0;
    logic         wr_valid;
    logic [31:0]  wr_addr;
    logic [127:0] wr_data;
    logic [15:0]  wr_be;
    logic         wr_ack = 1'b0;
    logic         last_seen;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qword_landing_bridge dut_i (
        .clk          (clk),
        .rst          (rst),
        .beat_valid_i (beat_valid),
        .beat_data_i  (beat_data),
        .beat_last_i  (beat_last),
        .beat_ready_o (beat_ready),
        .rewind_i     (rewind),
        .wr_valid_o   (wr_valid),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data),
        .wr_be_o      (wr_be),
        .wr_ack_i     (wr_ack),
        .last_seen_o  (last_seen)
    );

    task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic send_beat(input logic [31:0] d, input logic last);
        @(negedge clk);
        beat_valid = 1'b1; beat_data = d; beat_last = last;
        while (!beat_ready) @(negedge clk);
        @(posedge clk); #1;
        beat_valid = 1'b0; beat_last = 1'b0;
    endtask

    task automatic send_quad(input logic [31:0] seed);
        for (int i = 0; i < 4; i++) send_beat(seed + 32'(i), 1'b0);
    endtask

    task automatic take_write(input string req, input logic [31:0] ea,
                              input logic [127:0] ed, input logic [15:0] eb);
        logic [127:0] held;
        int n = 0;
        @(negedge clk);
        while (!wr_valid && n < 50) begin @(negedge clk); n++; end
        chk({req, " R5 write raised"}, 128'(wr_valid), 128'(1));
        chk({req, " R3 address"}, 128'(wr_addr), 128'(ea));
        chk({req, " R2 data"}, wr_data, ed);
        chk({req, " byte enables"}, 128'(wr_be), 128'(eb));
        held = wr_data;
        beat_valid = 1'b1; beat_data = 32'hBAD0_BAD0;
        repeat (2) @(negedge clk);
        chk({req, " R5 held, ready low"}, 128'({wr_valid, beat_ready}), 128'(2'b10));
        chk({req, " R5 data stable"}, wr_data, held);
        beat_valid = 1'b0;
        wr_ack = 1'b1;
        @(posedge clk); #1;
        wr_ack = 1'b0;
        @(negedge clk);
        chk({req, " R5 release"}, 128'({wr_valid, beat_ready}), 128'(2'b01));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ready", 128'(beat_ready), 128'(1));
        chk("R1 wr_valid", 128'(wr_valid), 128'(0));
        chk("R1 last_seen", 128'(last_seen), 128'(0));
    endtask

    task automatic t_stream;
        send_quad(32'h1000_0000);
        take_write("stream0 R4", BASE, {32'h1000_0003, 32'h1000_0002, 32'h1000_0001, 32'h1000_0000}, 16'hFFFF);
        send_quad(32'h2000_0010);
        take_write("stream1 R4", BASE + 32'd16, {32'h2000_0013, 32'h2000_0012, 32'h2000_0011, 32'h2000_0010}, 16'hFFFF);
        send_quad(32'hA5A5_0000);
        take_write("stream2 R3", BASE + 32'd32, {32'hA5A5_0003, 32'hA5A5_0002, 32'hA5A5_0001, 32'hA5A5_0000}, 16'hFFFF);
        chk("R8 no last flag yet", 128'(last_seen), 128'(0));
    endtask

    task automatic t_partial;
        send_beat(32'hCAFE_0001, 1'b0);
        send_beat(32'hCAFE_0002, 1'b1);
        take_write("partial R6", BASE + 32'd48, {64'h0, 32'hCAFE_0002, 32'hCAFE_0001}, 16'h00FF);
        chk("R8 last_seen set", 128'(last_seen), 128'(1));
    endtask

    task automatic t_rewind;
        @(negedge clk); rewind = 1'b1;
        @(posedge clk); #1; rewind = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 rewind starts no write", 128'(wr_valid), 128'(0));
        chk("R8 rewind keeps last_seen", 128'(last_seen), 128'(1));
        send_quad(32'h7700_0000);
        take_write("rewound R7", BASE, {32'h7700_0003, 32'h7700_0002, 32'h7700_0001, 32'h7700_0000}, 16'hFFFF);
        send_quad(32'h8800_0000);
        take_write("after rewind R3", BASE + 32'd16, {32'h8800_0003, 32'h8800_0002, 32'h8800_0001, 32'h8800_0000}, 16'hFFFF);
    endtask

    task automatic t_stray_ack;
        @(negedge clk); wr_ack = 1'b1;
        @(posedge clk); #1; wr_ack = 1'b0;
        @(negedge clk);
        chk("R5 stray ack no write", 128'(wr_valid), 128'(0));
        send_quad(32'h3300_0000);
        take_write("stray ack R5", BASE + 32'd32, {32'h3300_0003, 32'h3300_0002, 32'h3300_0001, 32'h3300_0000}, 16'hFFFF);
        chk("R8 still set", 128'(last_seen), 128'(1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_stream();
        t_partial();
        t_rewind();
        t_stray_ack();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule